// File: doc/BRIEF.md
# Time-Shared Adaptive FIR Filter Datapath

This block is the arithmetic core of an adaptive FIR filter trained by the least-mean-squares rule. A single multiplier and a single adder serve every step of the work. Operand multiplexers, steered by a small phase controller, give the two units a different job in each cycle. Each start strobe opens one iteration. The iteration pushes a new input sample into a tap delay line and captures the desired sample. It then runs the filter sum one tap per cycle. Next it forms the error as desired minus filter output. Last, it adjusts every tap weight by a scaled product of the error and the sample stored for that tap.

All stored quantities are 8-bit two's complement values. The multiplier result loses its 4 least significant bits, which leaves a 12-bit product. During weight adaptation that product is also shifted right arithmetically by a fixed step-size shift. Every adder result is cut back to its low 8 bits before it is stored. The error stays on the output until the next iteration computes a new one. A one-cycle done pulse marks the end of each adaptation pass.

Top module: `lms_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the error output, done, all stored samples and all weights are set to zero, so that the first iteration after reset produces an error equal to its desired sample.
- R2: A start accepted while idle shifts `x_in` into the delay line as the newest sample, drops the oldest, and captures `d_in` as the desired value for that iteration.
- R3: In the summing phase the accumulator is cleared at acceptance, then for each tap takes acc + P, where P is bits [15:4] of the signed 16-bit product weight × sample, read as a signed 12-bit value.
- R4: The error is (desired − accumulated output), taken as the low 8 bits. It is written once per iteration, after the summing phase, and holds its value at all other times.
- R5: In the adaptation phase, which always follows the error phase, each weight becomes w + (P >>> 5), where P is bits [15:4] of error × sample and >>> is an arithmetic shift of the 12-bit value.
- R6: Tap k (k = 0 to N_TAPS−1) pairs weight k with the sample pushed k starts earlier, where k = 0 is the newest. Taps are visited in ascending k in both phases.
- R7: `done` is high for exactly one cycle. It goes high after the 2·N_TAPS+1-th rising edge that follows the edge that accepted the start.
- R8: A start that arrives while an iteration is in progress is ignored. It changes neither the delay line, nor the desired value, nor the timing of the running iteration.
- R9: Every adder result, whether accumulator, error or weight, wraps to its low 8 bits in two's complement. No saturation is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins one iteration when the datapath is idle |
| d_in | input | 8 | Desired sample, signed |
| x_in | input | 8 | Input sample for the delay line, signed |
| err | output | 8 | Latest error, signed |
| done | output | 1 | One-cycle pulse at the end of weight adaptation |

## Verification
The bench builds the block with its defaults: eight taps, 8-bit data and a step shift of 5. With eight taps, the first eight starts fill the delay line from zeros. Later starts push samples off its far end, so both the fill and the discard behaviour are exercised. The adaptation uses a fixed shift of 5, and full-scale stimulus grows the weights fast enough that the accumulator and error sums wrap within a few iterations. The latency of 2·8+1 edges is measured on every iteration.

// File: rtl/lms_pkg.sv
package lms_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACC  = 2'd1,
        PH_ERR  = 2'd2,
        PH_UPD  = 2'd3
    } phase_e;

    typedef struct packed {
        logic acc_clr;
        logic acc_we;
        logic err_we;
        logic w_we;
        logic push;
    } ctl_s;

    function automatic int tap_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lms_ctrl.sv
module lms_ctrl
    import lms_pkg::*;
#(
    parameter int N_TAPS = 8,
    localparam int TW = tap_bits(N_TAPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output phase_e        phase,
    output logic [TW-1:0] tap,
    output ctl_s          ctl,
    output logic          done
);

    localparam logic [TW-1:0] LAST = TW'(N_TAPS - 1);

    phase_e        phase_q, phase_d;
    logic [TW-1:0] tap_q, tap_d;
    logic          done_d;
    logic          last_tap;

    assign last_tap = (tap_q == LAST);

    always_comb begin
        phase_d = phase_q;
        tap_d   = tap_q;
        done_d  = 1'b0;
        ctl     = '0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_d     = PH_ACC;
                    tap_d       = '0;
                    ctl.acc_clr = 1'b1;
                    ctl.push    = 1'b1;
                end
            end
            PH_ACC: begin
                ctl.acc_we = 1'b1;
                if (last_tap) begin
                    phase_d = PH_ERR;
                    tap_d   = '0;
                end else begin
                    tap_d = tap_q + 1'b1;
                end
            end
            PH_ERR: begin
                ctl.err_we = 1'b1;
                phase_d    = PH_UPD;
                tap_d      = '0;
            end
            PH_UPD: begin
                ctl.w_we = 1'b1;
                if (last_tap) begin
                    phase_d = PH_IDLE;
                    tap_d   = '0;
                    done_d  = 1'b1;
                end else begin
                    tap_d = tap_q + 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            tap_q   <= '0;
            done    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            tap_q   <= tap_d;
            done    <= done_d;
        end
    end

    assign phase = phase_q;
    assign tap   = tap_q;

endmodule

// File: rtl/lms_delay_line.sv
module lms_delay_line #(
    parameter int N_TAPS = 8,
    parameter int DW     = 8,
    parameter int TW     = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] x_in,
    input  logic [TW-1:0] sel,
    output logic [DW-1:0] x_out
);

    logic [DW-1:0] slot [N_TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            slot[0] <= '0;
        end else if (push) begin
            slot[0] <= x_in;
        end
    end

    for (genvar k = 1; k < N_TAPS; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[k] <= '0;
            end else if (push) begin
                slot[k] <= slot[k-1];
            end
        end
    end

    assign x_out = slot[sel];

endmodule

// File: rtl/lms_weight_store.sv
module lms_weight_store #(
    parameter int N_TAPS = 8,
    parameter int DW     = 8,
    parameter int TW     = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [TW-1:0] sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] wt [N_TAPS];

    for (genvar k = 0; k < N_TAPS; k++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                wt[k] <= '0;
            end else if (we && (sel == TW'(k))) begin
                wt[k] <= wdata;
            end
        end
    end

    assign rdata = wt[sel];

endmodule

// File: rtl/lms_alu.sv
module lms_alu
    import lms_pkg::*;
#(
    parameter int DW       = 8,
    parameter int DROP     = 4,
    parameter int MU_SHIFT = 5,
    localparam int FW = 2 * DW,
    localparam int PW = FW - DROP
) (
    input  phase_e        mode,
    input  logic [DW-1:0] w,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] d,
    input  logic [DW-1:0] e,
    output logic [DW-1:0] result
);

    logic signed [DW-1:0] mul_a;
    logic signed [FW-1:0] prod;
    logic signed [PW-1:0] p_plain;
    logic signed [PW-1:0] p_scaled;
    logic        [PW-1:0] prod_sel;
    logic        [PW-1:0] add_a;
    logic        [PW-1:0] add_b;
    logic                 cin;
    logic        [PW-1:0] sum;
    logic                 upd;

    function automatic logic [PW-1:0] sext(input logic [DW-1:0] v);
        return {{(PW-DW){v[DW-1]}}, v};
    endfunction

    assign upd      = (mode == PH_UPD);
    assign mul_a    = upd ? e : w;
    assign prod     = mul_a * $signed(x);
    assign p_plain  = prod[FW-1:DROP];
    assign p_scaled = p_plain >>> MU_SHIFT;
    assign prod_sel = upd ? p_scaled : p_plain;

    always_comb begin
        add_a = sext(acc);
        add_b = prod_sel;
        cin   = 1'b0;
        unique case (mode)
            PH_ACC: begin
                add_a = sext(acc);
                add_b = prod_sel;
            end
            PH_ERR: begin
                add_a = sext(d);
                add_b = ~sext(acc);
                cin   = 1'b1;
            end
            PH_UPD: begin
                add_a = sext(w);
                add_b = prod_sel;
            end
            default: begin
                add_a = sext(acc);
                add_b = prod_sel;
            end
        endcase
    end

    assign sum    = add_a + add_b + PW'(cin);
    assign result = sum[DW-1:0];

endmodule

// File: rtl/lms_filter.sv
module lms_filter
    import lms_pkg::*;
#(
    parameter int N_TAPS   = 8,
    parameter int DW       = 8,
    parameter int DROP     = 4,
    parameter int MU_SHIFT = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] d_in,
    input  logic [DW-1:0] x_in,
    output logic [DW-1:0] err,
    output logic          done
);

    localparam int TW = tap_bits(N_TAPS);

    phase_e        phase;
    logic [TW-1:0] tap;
    ctl_s          ctl;
    logic [DW-1:0] x_cur;
    logic [DW-1:0] w_cur;
    logic [DW-1:0] alu_out;
    logic [DW-1:0] d_q;
    logic [DW-1:0] acc_q;
    logic [DW-1:0] err_q;

    lms_ctrl #(.N_TAPS(N_TAPS)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .phase (phase),
        .tap   (tap),
        .ctl   (ctl),
        .done  (done)
    );

    lms_delay_line #(.N_TAPS(N_TAPS), .DW(DW), .TW(TW)) u_xline (
        .clk   (clk),
        .rst   (rst),
        .push  (ctl.push),
        .x_in  (x_in),
        .sel   (tap),
        .x_out (x_cur)
    );

    lms_weight_store #(.N_TAPS(N_TAPS), .DW(DW), .TW(TW)) u_wts (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl.w_we),
        .sel   (tap),
        .wdata (alu_out),
        .rdata (w_cur)
    );

    lms_alu #(.DW(DW), .DROP(DROP), .MU_SHIFT(MU_SHIFT)) u_alu (
        .mode   (phase),
        .w      (w_cur),
        .x      (x_cur),
        .acc    (acc_q),
        .d      (d_q),
        .e      (err_q),
        .result (alu_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q   <= '0;
            acc_q <= '0;
            err_q <= '0;
        end else begin
            if (ctl.push)    d_q   <= d_in;
            if (ctl.acc_clr) acc_q <= '0;
            else if (ctl.acc_we) acc_q <= alu_out;
            if (ctl.err_we)  err_q <= alu_out;
        end
    end

    assign err = err_q;

endmodule

// File: rtl/lms_filter_chk.sv
module lms_filter_chk
    import lms_pkg::*;
#(
    parameter int N_TAPS = 8,
    parameter int DW     = 8,
    parameter int TW     = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          done,
    input logic [DW-1:0] err,
    input phase_e        phase,
    input logic [TW-1:0] tap,
    input logic [DW-1:0] d_q
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (err == '0 && !done));

    assert_err_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_ERR) |=> $stable(err));

    assert_err_then_update_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ERR) |=> (phase == PH_UPD));

    assert_tap_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        int'(tap) < N_TAPS);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(phase) == PH_UPD && int'($past(tap)) == N_TAPS - 1));

    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && start) |=> ($stable(d_q) && phase != PH_ACC || $past(phase) == PH_ACC));

endmodule

bind lms_filter lms_filter_chk #(.N_TAPS(N_TAPS), .DW(DW), .TW(TW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .done  (done),
    .err   (err),
    .phase (phase),
    .tap   (tap),
    .d_q   (d_q)
);

// File: tb/tb_lms_filter.sv
module tb_lms_filter;

    localparam int N  = 8;
    localparam int NV = 16;
    localparam int WATCHDOG_CYC = 150000;

    // each entry: {x, d}
    localparam logic [15:0] VEC [NV] = '{
        {8'sd40,   8'sd100},  {8'sd120, -8'sd90},  {-8'sd128, 8'sd127}, {8'sd127, -8'sd128},
        {8'sd3,    8'sd5},    {-8'sd77, 8'sd60},   {8'sd100,  8'sd100},  {8'sd127, 8'sd127},
        {-8'sd1,  -8'sd1},    {8'sd64, -8'sd64},   {8'sd127,  8'sd127},  {-8'sd128, -8'sd128},
        {8'sd90,   8'sd20},   {-8'sd50, 8'sd110},  {8'sd0,    8'sd0},    {8'sd127, -8'sd100}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] d_in = '0;
    logic [7:0] x_in = '0;
    logic [7:0] err;
    logic       done;

    int checks = 0;
    int errors = 0;
    int mx [N];
    int mw [N];
    int m_err;

    always #2 clk = ~clk;

    lms_filter dut (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .d_in  (d_in),
        .x_in  (x_in),
        .err   (err),
        .done  (done)
    );

    function automatic int t8(input int v);
        logic [7:0] b;
        b = v[7:0];
        return int'($signed(b));
    endfunction

    function automatic int p12(input int a, input int b);
        return (a * b) >>> 4;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < N; k++) begin
            mx[k] = 0;
            mw[k] = 0;
        end
        m_err = 0;
    endtask

    // R2, R3, R4, R5, R6, R9 reference
    task automatic model_iter(input int x, input int d);
        int acc;
        for (int k = N - 1; k > 0; k--) mx[k] = mx[k-1];
        mx[0] = x;
        acc = 0;
        for (int k = 0; k < N; k++) acc = t8(acc + p12(mw[k], mx[k]));
        m_err = t8(d - acc);
        for (int k = 0; k < N; k++) mw[k] = t8(mw[k] + (p12(m_err, mx[k]) >>> 5));
    endtask

    // one iteration; if poke, a second start is raised while busy (R8)
    task automatic run_iter(input int x, input int d, input bit poke, input string tag);
        int cnt;
        int pulses;
        @(negedge clk);
        x_in  = x[7:0];
        d_in  = d[7:0];
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        model_iter(x, d);
        cnt = 0;
        while (cnt < 100) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (poke && cnt == 3) begin
                x_in  = 8'd99;
                d_in  = 8'd77;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done) break;
        end
        start = 1'b0;
        check({tag, " R7 done latency"}, cnt, 2 * N + 1);
        check({tag, " R4 error value"}, int'($signed(err)), m_err);
        pulses = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (done) pulses++;
        end
        check({tag, " R7 done single pulse"}, pulses, 0);
        check({tag, " R4 error held"}, int'($signed(err)), m_err);
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset err", int'(err), 0);
        check("R1 reset done", int'(done), 0);

        // first iteration: weights zero, so error equals desired (R1, R3)
        run_iter(30, -45, 1'b0, "R1 first");
        check("R1 error equals desired", int'($signed(err)), -45);

        // table walk: R2, R3, R5, R6, R9 through the model
        for (int i = 0; i < NV; i++) begin
            run_iter(int'($signed(VEC[i][15:8])), int'($signed(VEC[i][7:0])), 1'b0, "R6 R9 vec");
        end

        // start raised while busy is ignored (R8); following iterations confirm the delay line
        run_iter(127, 127, 1'b1, "R8 busy");
        run_iter(-128, 50, 1'b0, "R8 after");
        run_iter(10, -10, 1'b1, "R8 busy2");
        run_iter(127, -128, 1'b0, "R2 R5 after");

        // reset in the middle of an iteration clears everything (R1)
        @(negedge clk);
        x_in  = 8'd100;
        d_in  = 8'd100;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-run reset err", int'(err), 0);
        check("R1 mid-run reset done", int'(done), 0);
        model_reset();
        run_iter(-60, 33, 1'b0, "R1 post-reset");
        check("R1 post-reset error equals desired", int'($signed(err)), 33);
        for (int i = 0; i < 6; i++) begin
            run_iter(127, (i % 2 == 0) ? 127 : -128, 1'b0, "R9 wrap");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule